// File: doc/BRIEF.md
# Posted Write Delivery Engine

This block drives buffered posted write data onto a target bus after the original requester has already been released. Nothing is reported back to that requester. The engine takes a descriptor: a starting DWORD address, a DWORD count and a command code. It then opens write attempts and watches how each one ends. From that ending it decides one of three things: open another attempt, finish, or give up. While it works it tracks the address of the next undelivered DWORD and the number of DWORDs still buffered.

Each attempt ends with one of four endings, and each ending has its own handling:
- **Retry:** the attempt is repeated exactly as it was.
- **Disconnect:** the transfer resumes at the first DWORD the target did not take.
- **Normal:** the transfer ends.
- **Abort:** the buffered data is dropped.

A memory-write-and-invalidate transfer that has delivered part of its data cannot finish with that command, because the rest no longer forms a whole line. The engine therefore falls back to a plain memory write for the rest.

A programmable attempt limit bounds the effort spent on one transfer. Two sticky status bits record a received abort and a signalled system error. A one-cycle system-error pulse is gated by an enable input, and the give-up case has an extra mask input.

Top module: `pw_deliver_engine`

## Requirements
- R1: After reset: `busy`, `att_start`, `rem_cnt`, `rcvd_tabort`, `sig_serr`, `serr_out` and `give_up` are all 0.
- R2: A `start` is accepted only while `busy` is 0 and `start_cnt` is nonzero. A `start` while busy, or with a zero count, has no effect. When a start is accepted, then in the next cycle:
  - `busy` is 1;
  - `att_start` pulses for one cycle;
  - `att_dwaddr` equals `start_dwaddr`;
  - `att_cmd` equals `start_cmd`;
  - `rem_cnt` equals `start_cnt`.
- R3: Bus inputs are sampled only while `busy` is 1 and `att_start` is 0. Each sampled `dw_ack` with a nonzero `rem_cnt` lowers `rem_cnt` by one in the next cycle. When `term_valid` and `dw_ack` arrive together, the acknowledged DWORD counts first.
- R4: The `term_code` encoding is 2'b00 normal, 2'b01 retry, 2'b10 disconnect, 2'b11 abort. A normal ending, or a disconnect that leaves no DWORD outstanding, makes `busy` 0 and `rem_cnt` 0 in the next cycle. No status bit changes.
- R5: A retry below the attempt limit starts a new attempt in the next cycle (`att_start` 1). That attempt has:
  - the same `att_dwaddr` as the retried attempt;
  - the same `att_cmd` as the retried attempt;
  - `rem_cnt` restored to its value when the retried attempt started.
- R6: A disconnect that leaves DWORDs outstanding, below the attempt limit, starts a new attempt in the next cycle. Its `att_dwaddr` is the previous attempt address plus the DWORDs acknowledged in that attempt, and its `rem_cnt` is the outstanding count.
- R7: When a disconnect starts a new attempt, the command changes only in one case: it was 4'b1111 (memory write and invalidate) and at least one DWORD of the transfer has been delivered. It then becomes 4'b0111 (memory write). It stays 4'b1111 if nothing has been delivered. Any other code is kept.
- R8: A transfer makes at most `ATT_LIMIT` attempts. The limit applies when a retry or disconnect needs another attempt after `ATT_LIMIT` attempts have been made. In the next cycle:
  - `give_up` pulses;
  - `busy` and `rem_cnt` go to 0;
  - `serr_out` pulses and `sig_serr` is set, but only if `serr_en` is 1 and `nodeliv_mask` is 0.
- R9: An abort makes `busy` and `rem_cnt` 0 and sets `rcvd_tabort` in the next cycle. If `serr_en` is 1, `serr_out` also pulses and `sig_serr` is set, whatever `nodeliv_mask` is.
- R10: `rcvd_tabort` and `sig_serr` stay set until a cycle with `stat_clr` 1 clears them. A set event in the same cycle as `stat_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to deliver a new buffered transfer |
| start_dwaddr | input | AW | First DWORD address of the transfer |
| start_cnt | input | CW | Number of DWORDs buffered |
| start_cmd | input | 4 | Command code of the transfer |
| serr_en | input | 1 | System error reporting enable |
| nodeliv_mask | input | 1 | Suppresses system error on non-delivery |
| stat_clr | input | 1 | Clears both sticky status bits |
| dw_ack | input | 1 | Target accepted one DWORD |
| term_valid | input | 1 | Current attempt has ended |
| term_code | input | 2 | How the attempt ended |
| att_start | output | 1 | One-cycle pulse opening an attempt |
| att_dwaddr | output | AW | Start DWORD address of the current attempt |
| att_cmd | output | 4 | Command code of the current attempt |
| busy | output | 1 | A transfer is in progress |
| rem_cnt | output | CW | DWORDs still to deliver |
| rcvd_tabort | output | 1 | Sticky: an attempt was aborted |
| sig_serr | output | 1 | Sticky: a system error was signalled |
| serr_out | output | 1 | One-cycle system error pulse |
| give_up | output | 1 | One-cycle pulse when the attempt limit drops a transfer |

## Verification
The engine is tried with four kinds of stimulus:
- **Clean bursts**, which show that acknowledged DWORDs count down correctly.
- **Retries after partial acknowledgement**, which separate replaying the attempt from resuming it: only a replay restores the address and count.
- **Disconnects with and without data taken.** These tell apart a memory-write-and-invalidate transfer that must fall back to a plain write from one that must keep its command.
- **Repeated retries up to the limit under every `serr_en`/`nodeliv_mask` combination, plus aborts with reporting on and off.** These separate the give-up gating from the abort gating.

A behavioural model in the bench predicts every output in every cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [1:0] {
    TERM_NORMAL = 2'b00,
    TERM_RETRY  = 2'b01,
    TERM_DISC   = 2'b10,
    TERM_ABORT  = 2'b11
  } term_e;

  localparam logic [3:0] CMD_MEMWR = 4'b0111;
  localparam logic [3:0] CMD_MWI   = 4'b1111;

endpackage

// File: rtl/pw_addr_track.sv
module pw_addr_track #(
  parameter int AW = 30,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ack,
  input  logic          retry_rl,
  input  logic          disc_rl,
  input  logic          flush,
  output logic [AW-1:0] att_addr,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] rem,
  output logic [CW-1:0] orig_cnt
);
  logic [CW-1:0] att_rem;
  logic [AW-1:0] cur_next;
  logic [CW-1:0] rem_next;

  // Position after the DWORD (if any) taken in this cycle.
  assign cur_next = cur_addr + AW'(ack);
  assign rem_next = rem - CW'(ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      att_addr <= '0;
      cur_addr <= '0;
      rem      <= '0;
      att_rem  <= '0;
      orig_cnt <= '0;
    end else if (load) begin
      att_addr <= ld_addr;
      cur_addr <= ld_addr;
      rem      <= ld_cnt;
      att_rem  <= ld_cnt;
      orig_cnt <= ld_cnt;
    end else if (retry_rl) begin
      // Replay: whatever the target took in a retried attempt is void.
      cur_addr <= att_addr;
      rem      <= att_rem;
    end else if (disc_rl) begin
      cur_addr <= cur_next;
      att_addr <= cur_next;
      rem      <= rem_next;
      att_rem  <= rem_next;
    end else if (flush) begin
      cur_addr <= cur_next;
      rem      <= '0;
      att_rem  <= '0;
    end else if (ack) begin
      cur_addr <= cur_next;
      rem      <= rem_next;
    end
  end
endmodule

// File: rtl/pw_cmd_sel.sv
module pw_cmd_sel
  import pw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] ld_cmd,
  input  logic       downgrade,
  output logic [3:0] cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
    end else if (load) begin
      cmd <= ld_cmd;
    end else if (downgrade && cmd == CMD_MWI) begin
      cmd <= CMD_MEMWR;
    end
  end
endmodule

// File: rtl/pw_att_ctr.sv
module pw_att_ctr #(
  parameter int LIMIT = 1 << 24,
  parameter int ATW   = $clog2(LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           inc,
  output logic [ATW-1:0] count,
  output logic           at_limit
);
  localparam logic [ATW-1:0] LIM_V = ATW'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= ATW'(1);
    end else if (inc) begin
      count <= count + ATW'(1);
    end
  end

  assign at_limit = (count >= LIM_V);
endmodule

// File: rtl/pw_status.sv
module pw_status (
  input  logic clk,
  input  logic rst,
  input  logic abort_ev,
  input  logic giveup_ev,
  input  logic serr_en,
  input  logic nodeliv_mask,
  input  logic stat_clr,
  output logic rcvd_tabort,
  output logic sig_serr,
  output logic serr_out,
  output logic give_up
);
  logic serr_fire;

  assign serr_fire = serr_en && (abort_ev || (giveup_ev && !nodeliv_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      rcvd_tabort <= 1'b0;
      sig_serr    <= 1'b0;
      serr_out    <= 1'b0;
      give_up     <= 1'b0;
    end else begin
      rcvd_tabort <= abort_ev  || (rcvd_tabort && !stat_clr);
      sig_serr    <= serr_fire || (sig_serr && !stat_clr);
      serr_out    <= serr_fire;
      give_up     <= giveup_ev;
    end
  end
endmodule

// File: rtl/pw_deliver_engine.sv
module pw_deliver_engine
  import pw_pkg::*;
#(
  parameter int AW        = 30,
  parameter int CW        = 16,
  parameter int ATT_LIMIT = 1 << 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_dwaddr,
  input  logic [CW-1:0] start_cnt,
  input  logic [3:0]    start_cmd,
  input  logic          serr_en,
  input  logic          nodeliv_mask,
  input  logic          stat_clr,
  input  logic          dw_ack,
  input  logic          term_valid,
  input  logic [1:0]    term_code,
  output logic          att_start,
  output logic [AW-1:0] att_dwaddr,
  output logic [3:0]    att_cmd,
  output logic          busy,
  output logic [CW-1:0] rem_cnt,
  output logic          rcvd_tabort,
  output logic          sig_serr,
  output logic          serr_out,
  output logic          give_up
);
  localparam int ATW = $clog2(ATT_LIMIT + 1);

  logic           busy_q, att_start_q;
  logic [AW-1:0]  cur_addr;
  logic [CW-1:0]  orig_cnt;
  logic [CW-1:0]  rem_after;
  logic [ATW-1:0] att_cnt;
  logic           at_limit;
  logic           in_wait, ack, term, accept;
  logic           is_retry, is_disc, is_abort;
  logic           need_more, relaunch, giveup, finish, partial;
  term_e          code;

  assign code      = term_e'(term_code);
  assign in_wait   = busy_q && !att_start_q;
  assign ack       = in_wait && dw_ack && (rem_cnt != '0);
  assign term      = in_wait && term_valid;
  assign is_retry  = (code == TERM_RETRY);
  assign is_disc   = (code == TERM_DISC);
  assign is_abort  = (code == TERM_ABORT);
  assign rem_after = rem_cnt - CW'(ack);
  assign need_more = term && (is_retry || (is_disc && rem_after != '0));
  assign relaunch  = need_more && !at_limit;
  assign giveup    = need_more && at_limit;
  assign finish    = term && !relaunch;
  assign accept    = !busy_q && start && (start_cnt != '0);
  assign partial   = (rem_after != orig_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      att_start_q <= 1'b0;
    end else begin
      if (accept)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      att_start_q <= accept || relaunch;
    end
  end

  pw_addr_track #(.AW(AW), .CW(CW)) u_track (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .ld_addr  (start_dwaddr),
    .ld_cnt   (start_cnt),
    .ack      (ack),
    .retry_rl (relaunch && is_retry),
    .disc_rl  (relaunch && is_disc),
    .flush    (finish),
    .att_addr (att_dwaddr),
    .cur_addr (cur_addr),
    .rem      (rem_cnt),
    .orig_cnt (orig_cnt)
  );

  pw_cmd_sel u_cmd (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .ld_cmd    (start_cmd),
    .downgrade (relaunch && is_disc && partial),
    .cmd       (att_cmd)
  );

  pw_att_ctr #(.LIMIT(ATT_LIMIT), .ATW(ATW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .inc      (relaunch),
    .count    (att_cnt),
    .at_limit (at_limit)
  );

  pw_status u_stat (
    .clk          (clk),
    .rst          (rst),
    .abort_ev     (term && is_abort),
    .giveup_ev    (giveup),
    .serr_en      (serr_en),
    .nodeliv_mask (nodeliv_mask),
    .stat_clr     (stat_clr),
    .rcvd_tabort  (rcvd_tabort),
    .sig_serr     (sig_serr),
    .serr_out     (serr_out),
    .give_up      (give_up)
  );

  assign busy      = busy_q;
  assign att_start = att_start_q;
endmodule

// File: rtl/pw_deliver_checker.sv
module pw_deliver_checker #(
  parameter int AW        = 30,
  parameter int CW        = 16,
  parameter int ATT_LIMIT = 1 << 24,
  parameter int ATW       = 25
) (
  input logic           clk,
  input logic           rst,
  input logic           att_start,
  input logic [AW-1:0]  att_dwaddr,
  input logic [3:0]     att_cmd,
  input logic           busy,
  input logic [CW-1:0]  rem_cnt,
  input logic [CW-1:0]  orig_cnt,
  input logic [AW-1:0]  cur_addr,
  input logic [ATW-1:0] att_cnt,
  input logic           serr_en,
  input logic           serr_out,
  input logic           dw_ack,
  input logic           term_valid,
  input logic [1:0]     term_code
);
  localparam logic [ATW-1:0] LIM_V = ATW'(ATT_LIMIT);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !att_start);

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !att_start && dw_ack && !term_valid && rem_cnt != '0)
    |=> rem_cnt == $past(rem_cnt) - CW'(1));

  p_retry_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !att_start && term_valid && term_code == 2'b01 && att_cnt < LIM_V)
    |=> (att_start && att_dwaddr == $past(att_dwaddr)));

  p_disc_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !att_start && term_valid && term_code == 2'b10 &&
     rem_cnt != CW'(dw_ack) && att_cnt < LIM_V)
    |=> (att_start && att_dwaddr == $past(cur_addr) + AW'($past(dw_ack))));

  p_mwi_whole_r7: assert property (@(posedge clk) disable iff (rst)
    (att_start && att_cmd == 4'b1111) |-> rem_cnt == orig_cnt);

  p_att_bound_r8: assert property (@(posedge clk) disable iff (rst)
    att_cnt <= LIM_V);

  p_serr_gate_r9: assert property (@(posedge clk) disable iff (rst)
    serr_out |-> $past(serr_en));
endmodule

bind pw_deliver_engine pw_deliver_checker #(
  .AW(AW), .CW(CW), .ATT_LIMIT(ATT_LIMIT), .ATW(ATW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .att_start  (att_start),
  .att_dwaddr (att_dwaddr),
  .att_cmd    (att_cmd),
  .busy       (busy),
  .rem_cnt    (rem_cnt),
  .orig_cnt   (orig_cnt),
  .cur_addr   (cur_addr),
  .att_cnt    (att_cnt),
  .serr_en    (serr_en),
  .serr_out   (serr_out),
  .dw_ack     (dw_ack),
  .term_valid (term_valid),
  .term_code  (term_code)
);

// File: tb/tb_pw_deliver_engine.sv
module tb_pw_deliver_engine;
  localparam int AW = 16, CW = 8, LIM = 3;
  localparam logic [1:0] NRM = 2'b00, RTY = 2'b01, DSC = 2'b10, ABT = 2'b11;

  logic clk = 0, rst = 1;
  logic start = 0, serr_en = 0, nodeliv_mask = 0, stat_clr = 0;
  logic dw_ack = 0, term_valid = 0;
  logic [1:0] term_code = 0;
  logic [AW-1:0] start_dwaddr = 0;
  logic [CW-1:0] start_cnt = 0;
  logic [3:0] start_cmd = 0;
  logic att_start, busy, rcvd_tabort, sig_serr, serr_out, give_up;
  logic [AW-1:0] att_dwaddr;
  logic [3:0] att_cmd;
  logic [CW-1:0] rem_cnt;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pw_deliver_engine #(.AW(AW), .CW(CW), .ATT_LIMIT(LIM)) dut (.*);

  // Behavioural reference model
  int m_busy, m_ast, m_addr, m_cur, m_rem, m_arem, m_orig, m_cmd, m_atts;
  int m_rcv, m_sig, m_serr, m_gu;

  always @(posedge clk) begin
    int a, ra, ca, set_r, set_s, fin;
    if (rst) begin
      m_busy = 0; m_ast = 0; m_addr = 0; m_cur = 0; m_rem = 0; m_arem = 0;
      m_orig = 0; m_cmd = 0; m_atts = 0; m_rcv = 0; m_sig = 0; m_serr = 0; m_gu = 0;
    end else begin
      set_r = 0; set_s = 0; m_gu = 0; fin = 0;
      if (!m_busy) begin
        m_ast = 0;
        if (start && start_cnt != 0) begin
          m_busy = 1; m_ast = 1; m_addr = start_dwaddr; m_cur = start_dwaddr;
          m_rem = start_cnt; m_arem = start_cnt; m_orig = start_cnt;
          m_cmd = start_cmd; m_atts = 1;
        end
      end else if (m_ast) begin
        m_ast = 0;
      end else begin
        a = (dw_ack && m_rem > 0) ? 1 : 0;
        ra = m_rem - a; ca = m_cur + a;
        if (term_valid) begin
          if (term_code == ABT) begin
            set_r = 1; set_s = serr_en; fin = 1;
          end else if (term_code == RTY || (term_code == DSC && ra != 0)) begin
            if (m_atts >= LIM) begin
              m_gu = 1; set_s = serr_en && !nodeliv_mask; fin = 1;
            end else if (term_code == RTY) begin
              m_cur = m_addr; m_rem = m_arem; m_atts++; m_ast = 1;
            end else begin
              if (m_cmd == 15 && ra != m_orig) m_cmd = 7;
              m_cur = ca; m_addr = ca; m_rem = ra; m_arem = ra; m_atts++; m_ast = 1;
            end
          end else fin = 1;
          if (fin) begin m_busy = 0; m_rem = 0; m_cur = ca; end
        end else if (a) begin
          m_rem = ra; m_cur = ca;
        end
      end
      m_serr = set_s;
      m_rcv = set_r | (m_rcv & !stat_clr);
      m_sig = set_s | (m_sig & !stat_clr);
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 busy", busy, m_busy);
      check("R2 att_start", att_start, m_ast);
      check("R6 att_dwaddr", att_dwaddr, m_addr);
      check("R7 att_cmd", att_cmd, m_cmd);
      check("R3 rem_cnt", rem_cnt, m_rem);
      check("R8 give_up", give_up, m_gu);
      check("R9 rcvd_tabort", rcvd_tabort, m_rcv);
      check("R10 sig_serr", sig_serr, m_sig);
      check("R8 serr_out", serr_out, m_serr);
    end
  end

  task automatic step(input logic a, input logic tv, input logic [1:0] c);
    @(negedge clk);
    start = 0; dw_ack = a; term_valid = tv; term_code = c; stat_clr = 0;
  endtask

  task automatic launch(input int ad, input int n, input logic [3:0] cm);
    @(negedge clk);
    start = 1; start_dwaddr = AW'(ad); start_cnt = CW'(n); start_cmd = cm;
    dw_ack = 0; term_valid = 0; stat_clr = 0;
    step(0, 0, NRM);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0); check("R1 rem", rem_cnt, 0);
    check("R1 serr", serr_out, 0); check("R1 sig", sig_serr, 0);
    rst = 0;
    // R4: clean burst of 4, last ack with normal ending
    launch('h100, 4, 4'b0111);
    check("R2 att_dwaddr", att_dwaddr, 'h100);
    check("R2 rem", rem_cnt, 4);
    step(1, 0, NRM); step(1, 0, NRM); step(1, 0, NRM); step(1, 1, NRM);
    step(0, 0, NRM);
    check("R4 busy after normal", busy, 0);
    // R2: zero count ignored
    launch('h50, 0, 4'b0111);
    check("R2 zero count ignored", busy, 0);
    // R5 / R7: MWI, retry after 2 acks, then partial disconnect
    launch('h200, 4, 4'b1111);
    step(1, 0, NRM); step(1, 1, RTY); step(0, 0, NRM);
    check("R5 retry addr", att_dwaddr, 'h200);
    check("R5 retry rem", rem_cnt, 4);
    check("R7 MWI kept on retry", att_cmd, 4'b1111);
    step(0, 0, NRM); step(1, 1, DSC); step(0, 0, NRM);
    check("R6 disc addr", att_dwaddr, 'h201);
    check("R6 disc rem", rem_cnt, 3);
    check("R7 downgraded", att_cmd, 4'b0111);
    step(1, 0, NRM); step(1, 0, NRM); step(1, 1, DSC); step(0, 0, NRM);
    check("R4 disc at zero ends", busy, 0);
    // R7: MWI disconnect with nothing delivered keeps MWI
    launch('h300, 2, 4'b1111);
    step(0, 1, DSC); step(0, 0, NRM);
    check("R7 MWI kept", att_cmd, 4'b1111);
    step(0, 0, NRM); step(0, 1, NRM); step(0, 0, NRM);
    check("R4 normal discards", rem_cnt, 0);
    // R8: limit with serr enabled, unmasked; start while busy ignored
    serr_en = 1;
    launch('h400, 2, 4'b0111);
    @(negedge clk); start = 1; start_dwaddr = 'h777; start_cnt = 5;
    step(0, 1, RTY); step(0, 0, NRM); step(0, 0, NRM);
    check("R2 start while busy ignored", att_dwaddr, 'h400);
    step(0, 1, RTY); step(0, 0, NRM); step(0, 1, RTY); step(0, 0, NRM);
    check("R8 give_up", give_up, 1);
    check("R8 serr pulse", serr_out, 1);
    step(0, 0, NRM);
    @(negedge clk); stat_clr = 1; step(0, 0, NRM);
    check("R10 cleared", sig_serr, 0);
    // R8: masked
    nodeliv_mask = 1;
    launch('h500, 1, 4'b0111);
    step(0, 1, RTY); step(0, 0, NRM); step(0, 1, RTY); step(0, 0, NRM);
    step(0, 1, RTY); step(0, 0, NRM);
    check("R8 masked no serr", serr_out, 0);
    check("R8 masked give_up", give_up, 1);
    // R9: abort with serr enabled despite mask, set wins over clear
    launch('h600, 3, 4'b0111);
    step(1, 0, NRM);
    @(negedge clk); dw_ack = 0; term_valid = 1; term_code = ABT; stat_clr = 1;
    step(0, 0, NRM);
    check("R9 abort rcvd", rcvd_tabort, 1);
    check("R10 set beats clear", sig_serr, 1);
    check("R9 abort rem", rem_cnt, 0);
    // R9: abort with reporting off
    serr_en = 0; nodeliv_mask = 0;
    @(negedge clk); stat_clr = 1; step(0, 0, NRM);
    launch('h700, 2, 4'b0111);
    step(0, 1, ABT); step(0, 0, NRM);
    check("R9 abort no serr", sig_serr, 0);
    check("R9 abort rcvd again", rcvd_tabort, 1);
    // R8: serr disabled at limit
    launch('h800, 2, 4'b0111);
    step(1, 1, DSC); step(0, 0, NRM); step(0, 1, RTY); step(0, 0, NRM);
    step(0, 1, RTY); step(0, 0, NRM);
    check("R8 disabled give_up", give_up, 1);
    check("R8 disabled no serr", serr_out, 0);
    repeat (3) step(0, 0, NRM);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule